// File: doc/BRIEF.md
# Interrupt Summary and Mask Controller

This block collects nineteen level-sensitive interrupt lines into one request to the processor. The lines come from four expansion slots with four pins each, a bridge cascade, a disk controller and a USB controller. Every line passes through a two-flop synchronizer. Each line also has a disable bit in a write-only mask. The request output is high while any line is active and its mask bit is clear.

Software reaches the block over a byte-wide I/O bus with address, write data, read data and single-cycle read and write strobes. It uses three consecutive byte addresses starting at a base parameter. A write to one of these addresses replaces that byte of the mask. A read from one of them returns the synchronized raw line state for that byte. The mask is never applied to reads, and the mask cannot be read back. Start-up code normally writes 0xFF to all three bytes to quiet every source, then clears bits as drivers attach.

Top module: `irq_summary_mask`

## Requirements
- R1: After reset, all nineteen mask bits are 1, `irq_req` is low and `bus_rdata` is 0x00.
- R2: A write strobe at address BASE+k (k = 0, 1, 2) loads `bus_wdata` bit j into the mask bit of line 8k+j. A 1 disables the line and a 0 enables it. Mask bytes at other offsets keep their values.
- R3: `irq_req` is high exactly when some line is active (synchronized level 1) and its mask bit is 0. It stays high for as long as that holds.
- R4: A read strobe at BASE+k loads `bus_rdata` on the next clock edge with the synchronized raw state of lines 8k to 8k+7. The mask has no effect on this value.
- R5: Line n appears at offset n/8, bit n%8. Offset 0 bits 0-7 are: slot 0-3 pin A, bridge cascade, disk, USB, slot 0 pin B. Offset 1 bits 0-7 are: slot 1-3 pin B, slot 0-3 pin C, slot 0 pin D. Offset 2 bits 0-2 are slot 1-3 pin D.
- R6: Offset 2 bits 3-7 are reserved. They read as 0, and writing them has no effect.
- R7: A change on `irq_lines` reaches `irq_req` and read data after two clock edges, not one.
- R8: A read or write at an address outside BASE..BASE+2 leaves the mask unchanged. Such a read returns 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 12 | I/O address |
| bus_wdata | input | 8 | Write data |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_rdata | output | 8 | Read data, valid the cycle after the strobe |
| irq_lines | input | 19 | Asynchronous level interrupt inputs |
| irq_req | output | 1 | Combined interrupt request, active high |

## Verification
The bench walks a single active line across all nineteen positions. For each position it reads all three offsets, which separates the correct bit placement from shifted or swapped mappings. For each position it also opens only that line's mask bit, and then opens every bit except that one. These two cases tell a correct AND-NOT combination apart from inverted mask polarity or a mask bit wired to the wrong line. Mixed multi-line patterns read under a full mask show that reads ignore the mask. A one-edge versus two-edge probe pins the synchronizer depth. Writes and reads just outside the window show that the decode stays inside its three bytes.

// File: rtl/isc_pkg.sv
package isc_pkg;
  localparam int LINES   = 19;
  localparam int BYTE_W  = 8;
  localparam int NREGS   = (LINES + BYTE_W - 1) / BYTE_W;
  localparam int PADDED  = NREGS * BYTE_W;
  localparam int ADDR_W  = 12;
  localparam logic [ADDR_W-1:0] BASE = 12'h804;
endpackage

// File: rtl/isc_sync.sv
module isc_sync #(
  parameter int W = 19
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d_async,
  output logic [W-1:0] d_sync
);
  logic [W-1:0] stage1;
  logic [W-1:0] stage2;

  for (genvar i = 0; i < W; i++) begin : g_bit
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stage1[i] <= 1'b0;
        stage2[i] <= 1'b0;
      end else begin
        stage1[i] <= d_async[i];
        stage2[i] <= stage1[i];
      end
    end
  end

  assign d_sync = stage2;
endmodule

// File: rtl/isc_mask_regs.sv
module isc_mask_regs
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NREGS-1:0]  wr_sel,
  input  logic [BYTE_W-1:0] wdata,
  output logic [LINES-1:0]  mask
);
  for (genvar n = 0; n < LINES; n++) begin : g_mbit
    localparam int REG = n / BYTE_W;
    localparam int POS = n % BYTE_W;
    always_ff @(posedge clk) begin
      if (!rst_n)           mask[n] <= 1'b1;
      else if (wr_sel[REG]) mask[n] <= wdata[POS];
    end
  end

  assert_write_low_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_sel[0] |=> (mask[BYTE_W-1:0] == $past(wdata)));
  assert_hold_without_write_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_sel == '0) |=> $stable(mask));
endmodule

// File: rtl/isc_read_port.sv
module isc_read_port
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd,
  input  logic [NREGS-1:0]  rd_sel,
  input  logic [LINES-1:0]  status,
  output logic [BYTE_W-1:0] rdata
);
  logic [PADDED-1:0] padded;
  logic [BYTE_W-1:0] picked;

  assign padded = {{(PADDED-LINES){1'b0}}, status};

  always_comb begin
    picked = '0;
    for (int k = 0; k < NREGS; k++)
      if (rd_sel[k]) picked = picked | padded[k*BYTE_W +: BYTE_W];
  end

  always_ff @(posedge clk) begin
    if (!rst_n)  rdata <= '0;
    else if (rd) rdata <= picked;
  end

  assert_reserved_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_sel[NREGS-1]) |=> (rdata[BYTE_W-1:LINES-(NREGS-1)*BYTE_W] == '0));
  assert_outside_read_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (rd && rd_sel == '0) |=> (rdata == '0));
endmodule

// File: rtl/irq_summary_mask.sv
module irq_summary_mask
  import isc_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  input  logic              bus_wr,
  input  logic              bus_rd,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic [LINES-1:0]  irq_lines,
  output logic              irq_req
);
  logic [NREGS-1:0] addr_hit;
  logic [NREGS-1:0] wr_sel;
  logic [LINES-1:0] status;
  logic [LINES-1:0] mask;

  for (genvar k = 0; k < NREGS; k++) begin : g_dec
    assign addr_hit[k] = (bus_addr == BASE + ADDR_W'(k));
    assign wr_sel[k]   = bus_wr && addr_hit[k];
  end

  isc_sync #(.W(LINES)) u_sync (
    .clk(clk), .rst_n(rst_n), .d_async(irq_lines), .d_sync(status)
  );

  isc_mask_regs u_mask (
    .clk(clk), .rst_n(rst_n), .wr_sel(wr_sel), .wdata(bus_wdata), .mask(mask)
  );

  isc_read_port u_rd (
    .clk(clk), .rst_n(rst_n), .rd(bus_rd), .rd_sel(addr_hit),
    .status(status), .rdata(bus_rdata)
  );

  assign irq_req = |(status & ~mask);

  assert_reset_all_masked_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (mask == '1 && !irq_req));
  assert_masked_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == '1) |-> !irq_req);
  assert_req_needs_source_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (status != '0));
  assert_quiet_lines_no_req_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(irq_lines) == '0 && irq_lines == '0 && status == '0) |-> !irq_req);
endmodule

// File: tb/irq_summary_mask_tb.sv
module irq_summary_mask_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic [7:0]  bus_rdata;
  logic [18:0] irq_lines = '0;
  logic        irq_req;

  int checks = 0;
  int errors = 0;
  logic [18:0] mdl_mask;
  localparam logic [11:0] B = 12'h804;

  always #4 clk = ~clk;

  irq_summary_mask u_dut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wdata(bus_wdata),
    .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_rdata(bus_rdata),
    .irq_lines(irq_lines), .irq_req(irq_req)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
    for (int j = 0; j < 8; j++)
      for (int k = 0; k < 3; k++)
        if (a == B + 12'(k) && k*8+j < 19) mdl_mask[k*8+j] = d[j];
  endtask

  task automatic rd_chk(input string req, input logic [11:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    @(negedge clk);
    bus_rd = 1'b0;
    chk(req, {24'd0, bus_rdata}, {24'd0, exp});
  endtask

  task automatic set_lines(input logic [18:0] v);
    @(negedge clk);
    irq_lines = v;
    repeat (2) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [7:0] exp_byte(input logic [18:0] v, input int k);
    logic [23:0] p;
    p = {5'd0, v};
    return p[k*8 +: 8];
  endfunction

  task automatic write_mask(input logic [18:0] m);
    logic [23:0] p;
    p = {5'b11111, m};
    wr(B, p[7:0]); wr(B + 12'd1, p[15:8]); wr(B + 12'd2, p[23:16]);
  endtask

  initial begin
    #2000000;
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    mdl_mask = '1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    chk("R1 irq", {31'd0, irq_req}, 32'd0);
    chk("R1 rdata", {24'd0, bus_rdata}, 32'd0);
    set_lines('1);
    chk("R1 all masked", {31'd0, irq_req}, 32'd0);

    // R5 / R4 / R2 / R3: walk one line through every position
    for (int n = 0; n < 19; n++) begin
      logic [18:0] v;
      v = 19'd1 << n;
      write_mask('1);
      set_lines(v);
      for (int k = 0; k < 3; k++)
        rd_chk("R5 layout", B + 12'(k), exp_byte(v, k));
      chk("R3 masked", {31'd0, irq_req}, 32'd0);
      write_mask(~v);
      chk("R3 own bit open", {31'd0, irq_req}, 32'd1);
      rd_chk("R4 read ignores mask", B + 12'(n/8), exp_byte(v, n/8));
      write_mask(v);
      chk("R2 other bits open", {31'd0, irq_req}, 32'd0);
    end

    // R4: mixed patterns under full mask
    write_mask('1);
    for (int p = 0; p < 4; p++) begin
      logic [18:0] v;
      v = 19'(32'h5A3C7 * (p + 1) ^ (32'h1F0F1 >> p));
      set_lines(v);
      for (int k = 0; k < 3; k++)
        rd_chk("R4 raw status", B + 12'(k), exp_byte(v, k));
    end

    // R2: byte isolation
    set_lines('1);
    wr(B + 12'd1, 8'h00);
    chk("R2 byte1 opens", {31'd0, irq_req}, 32'd1);
    set_lines(19'h700FF);
    chk("R2 bytes 0,2 still closed", {31'd0, irq_req}, 32'd0);
    wr(B + 12'd1, 8'hFF);

    // R6: reserved bits
    set_lines('1);
    wr(B + 12'd2, 8'h07);
    chk("R6 reserved write no effect", {31'd0, irq_req}, 32'd0);
    rd_chk("R6 reserved read zero", B + 12'd2, 8'h07);
    wr(B + 12'd2, 8'hF8);
    chk("R6 low bits opened", {31'd0, irq_req}, 32'd1);
    write_mask('1);

    // R8: out-of-window accesses
    wr(B - 12'd1, 8'h00);
    wr(B + 12'd3, 8'h00);
    chk("R8 outside write", {31'd0, irq_req}, 32'd0);
    rd_chk("R8 outside read low", B - 12'd1, 8'h00);
    rd_chk("R8 outside read high", B + 12'd3, 8'h00);

    // R7: two-edge synchronizer
    set_lines('0);
    write_mask('0);
    @(negedge clk);
    irq_lines = 19'h00010;
    @(negedge clk);
    chk("R7 after one edge", {31'd0, irq_req}, 32'd0);
    @(negedge clk);
    chk("R7 after two edges", {31'd0, irq_req}, 32'd1);
    @(negedge clk);
    irq_lines = '0;
    @(negedge clk);
    chk("R7 level held", {31'd0, irq_req}, 32'd1);
    @(negedge clk);
    chk("R3 drops with line", {31'd0, irq_req}, 32'd0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule